// File: doc/BRIEF.md
# GPIO Bank with Grouped Interrupt Causes

This block is a bank of general-purpose lines behind a small register port. Each line can be an input or an output. An output line shows either a static value held in a register or a shared slow toggle for blinking a LED. Every pad input passes through a two-flop synchroniser and then a per-line polarity inverter. The result is registered as the data-in word, which software reads directly.

Interrupts come from two sources. The first is level: the data-in word itself, gated by a level mask. The second is edge: a sticky cause word that records every 0-to-1 change of the polarity-adjusted input, gated by its own mask. The two masked sources are ORed per line. Each run of eight consecutive lines then collapses into one group request for a main interrupt controller. Because the inverter sits ahead of the detector, one rising-edge detector covers both edge directions. Setting the polarity bit turns a falling pad edge into a rising one. Software can also track both edges by flipping the polarity after each event.

The register port is a plain control interface. A write takes effect at the clock edge where `reg_wr` is high. Read data is combinational from `reg_addr`. There is no back-pressure, and every access completes at once. Bits [4:2] of `reg_addr` select the register, and bits [1:0] are ignored. The word offsets are:

| Offset | Register |
|---|---|
| 0x00 | output value |
| 0x04 | direction (1 = input) |
| 0x08 | blink enable |
| 0x0C | input polarity |
| 0x10 | data-in (read only) |
| 0x14 | edge cause |
| 0x18 | edge mask |
| 0x1C | level mask |

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the direction register reads all ones, so every line is an input. Every other register reads zero, `pad_oe` is zero, `pad_out` is zero and `irq_grp` is zero.
- R2: The output value, direction, blink enable, polarity, edge mask and level mask registers each read back the last value written to them.
- R3: `pad_oe[i]` is 1 exactly when direction bit i is 0. An output line that is not blinking drives `pad_out[i]` equal to output value bit i. An input line drives `pad_out[i]` as 0.
- R4: Data-in (offset 0x10) reads the pad level XOR the polarity bit. A pad change shows up in a read after the third rising clock edge and not after the second. A change of polarity shows up after one edge. A write to 0x10 has no effect.
- R5: An edge cause bit becomes 1 at the clock edge after its data-in bit goes from 0 to 1. It stays 1 when the input returns low.
- R6: A write to the edge cause register (0x14) clears each bit written as 0 and keeps each bit written as 1. If a new rising edge reaches a bit in the same cycle as a write that clears it, the bit ends up 1.
- R7: A level cause is data-in AND level mask. It is not sticky: it follows the input, including an input inverted by polarity.
- R8: An edge cause raises an interrupt only while its edge mask bit is 1.
- R9: The per-line cause is (data-in AND level mask) OR (edge cause AND edge mask). `irq_grp[g]` is the OR of the causes of lines 8g to 8g+7, and a line affects no other group.
- R10: An output line whose blink bit is 1 toggles `pad_out[i]` every BLINK_HALF clock cycles, from one shared divider. A blink bit on an input line leaves its `pad_out` at 0. Clearing the blink bit restores the static output value.
- R11: With polarity bit 1, a falling pad edge sets that line's edge cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 5 | Byte address; bits [4:2] select the register |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Value driven toward each pad |
| pad_oe | output | 32 | Output enable per pad, 1 = drive |
| irq_grp | output | 4 | One interrupt request per group of eight lines |

## Verification
The bench builds the block with BLINK_HALF set to 4 and keeps the default of 32 lines in groups of eight. The short half period lets the bench count several whole blink periods, and the moment blinking is switched off, within a few dozen cycles. The full line count puts all four group outputs within reach, so the bench can show that each stimulated line lights only its own group. The exact three-edge input latency and the one-edge polarity latency are probed edge by edge. The clash between a rising edge and a clearing write is placed on the very same clock edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [2:0] {
    SEL_OUT    = 3'd0,
    SEL_DIR    = 3'd1,
    SEL_BLINK  = 3'd2,
    SEL_POL    = 3'd3,
    SEL_DIN    = 3'd4,
    SEL_ECAUSE = 3'd5,
    SEL_EMASK  = 3'd6,
    SEL_LMASK  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_blink.sv
module gpio_bank_blink #(
  parameter int HALF = 1 << 20
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      phase <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      phase <= ~phase;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int LINES = 32,
  parameter int GROUP = 8,
  localparam int NGRP = LINES / GROUP
) (
  input  logic [LINES-1:0] din,
  input  logic [LINES-1:0] lmask,
  input  logic [LINES-1:0] ecause,
  input  logic [LINES-1:0] emask,
  output logic [NGRP-1:0]  irq
);
  logic [LINES-1:0] line_cause;

  assign line_cause = (din & lmask) | (ecause & emask);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign irq[g] = |line_cause[g*GROUP +: GROUP];
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int LINES      = 32,
  parameter int GROUP      = 8,
  parameter int ADDR_W     = 5,
  parameter int BLINK_HALF = 1 << 20,
  localparam int NGRP      = LINES / GROUP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [LINES-1:0]  reg_wdata,
  output logic [LINES-1:0]  reg_rdata,
  input  logic [LINES-1:0]  pad_in,
  output logic [LINES-1:0]  pad_out,
  output logic [LINES-1:0]  pad_oe,
  output logic [NGRP-1:0]   irq_grp
);
  logic [LINES-1:0] out_q, dir_q, blink_q, pol_q;
  logic [LINES-1:0] din_q, din_prev_q, ecause_q, emask_q, lmask_q;
  logic [LINES-1:0] pad_sync, rise;
  logic             blink_phase;
  reg_sel_e         sel;

  assign sel = reg_sel_e'(reg_addr[2 +: 3]);

  gpio_bank_sync #(.W(LINES), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
  );

  gpio_bank_blink #(.HALF(BLINK_HALF)) u_blink (
    .clk(clk), .rst_n(rst_n), .phase(blink_phase)
  );

  // Writable configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '1;
      blink_q <= '0;
      pol_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else if (reg_wr) begin
      case (sel)
        SEL_OUT:   out_q   <= reg_wdata;
        SEL_DIR:   dir_q   <= reg_wdata;
        SEL_BLINK: blink_q <= reg_wdata;
        SEL_POL:   pol_q   <= reg_wdata;
        SEL_EMASK: emask_q <= reg_wdata;
        SEL_LMASK: lmask_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  // Polarity-adjusted input and its previous value for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q      <= '0;
      din_prev_q <= '0;
    end else begin
      din_q      <= pad_sync ^ pol_q;
      din_prev_q <= din_q;
    end
  end

  assign rise = din_q & ~din_prev_q;

  // Sticky edge causes: write-zero clears, a new edge overrides the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ecause_q <= '0;
    else if (reg_wr && sel == SEL_ECAUSE)
      ecause_q <= (ecause_q & reg_wdata) | rise;
    else
      ecause_q <= ecause_q | rise;
  end

  gpio_bank_irq #(.LINES(LINES), .GROUP(GROUP)) u_irq (
    .din(din_q), .lmask(lmask_q), .ecause(ecause_q), .emask(emask_q),
    .irq(irq_grp)
  );

  assign pad_oe  = ~dir_q;
  assign pad_out = ~dir_q & ((blink_q & {LINES{blink_phase}}) | (~blink_q & out_q));

  always_comb begin
    case (sel)
      SEL_OUT:    reg_rdata = out_q;
      SEL_DIR:    reg_rdata = dir_q;
      SEL_BLINK:  reg_rdata = blink_q;
      SEL_POL:    reg_rdata = pol_q;
      SEL_DIN:    reg_rdata = din_q;
      SEL_ECAUSE: reg_rdata = ecause_q;
      SEL_EMASK:  reg_rdata = emask_q;
      default:    reg_rdata = lmask_q;
    endcase
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int LINES      = 32,
  parameter int GROUP      = 8,
  parameter int ADDR_W     = 5,
  parameter int BLINK_HALF = 1 << 20,
  localparam int NGRP      = LINES / GROUP
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [LINES-1:0]  pad_in,
  input logic [LINES-1:0]  pol_q,
  input logic [LINES-1:0]  din_q,
  input logic [LINES-1:0]  ecause_q,
  input logic [LINES-1:0]  emask_q,
  input logic [LINES-1:0]  lmask_q,
  input logic [NGRP-1:0]   irq_grp,
  input logic              blink_phase
);
  localparam int CW = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(BLINK_HALF - 1);

  logic [2:0]    since_q;
  logic [CW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_q <= '0;
    else if (since_q != 3'd6) since_q <= since_q + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= '0;
    else if (gap_q == LAST) gap_q <= '0;
    else gap_q <= gap_q + 1'b1;
  end

  // R5: without a write to the cause word, no cause bit ever falls
  assert_cause_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr[4:2] == 3'd5) |=> ((ecause_q & $past(ecause_q)) == $past(ecause_q)));

  // R8: with both masks clear no group requests
  assert_masks_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (emask_q == '0 && lmask_q == '0) |-> (irq_grp == '0));

  // R4: settled pads and polarity give data-in = pad XOR polarity
  assert_din_settled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q >= 3'd5 && pad_in == $past(pad_in) && pad_in == $past(pad_in, 2) &&
     pad_in == $past(pad_in, 3) && pad_in == $past(pad_in, 4) &&
     pol_q == $past(pol_q) && pol_q == $past(pol_q, 2))
    |-> (din_q == (pad_in ^ pol_q)));

  // R10: the blink phase toggles once per BLINK_HALF cycles and holds otherwise
  assert_blink_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q == LAST) |=> (blink_phase != $past(blink_phase)));
  assert_blink_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q != LAST) |=> $stable(blink_phase));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
  .LINES(LINES), .GROUP(GROUP), .ADDR_W(ADDR_W), .BLINK_HALF(BLINK_HALF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .pad_in(pad_in), .pol_q(pol_q), .din_q(din_q), .ecause_q(ecause_q),
  .emask_q(emask_q), .lmask_q(lmask_q), .irq_grp(irq_grp),
  .blink_phase(blink_phase)
);

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int A_OUT = 'h00, A_DIR = 'h04, A_BLINK = 'h08, A_POL = 'h0C;
  localparam int A_DIN = 'h10, A_ECAUSE = 'h14, A_EMASK = 'h18, A_LMASK = 'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic [3:0]  irq_grp;

  int n_checks = 0;
  int n_fail = 0;

  gpio_irq_bank #(.BLINK_HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_grp(irq_grp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; reg_wr = 1'b0; pad_in = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_addr = 5'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = 5'(a); reg_wr = 1'b0;
    #1;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rd(A_OUT, v);    check("R1 out", v, 32'h0);
    rd(A_DIR, v);    check("R1 dir", v, 32'hFFFF_FFFF);
    rd(A_BLINK, v);  check("R1 blink", v, 32'h0);
    rd(A_POL, v);    check("R1 pol", v, 32'h0);
    rd(A_DIN, v);    check("R1 din", v, 32'h0);
    rd(A_ECAUSE, v); check("R1 ecause", v, 32'h0);
    rd(A_EMASK, v);  check("R1 emask", v, 32'h0);
    rd(A_LMASK, v);  check("R1 lmask", v, 32'h0);
    check("R1 irq", 32'(irq_grp), 32'h0);
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    do_reset();
    wr(A_OUT, 32'h1111_2222);  wr(A_DIR, 32'h3333_4444);
    wr(A_BLINK, 32'h5555_6666); wr(A_POL, 32'h7777_8888);
    wr(A_EMASK, 32'h9999_AAAA); wr(A_LMASK, 32'hBBBB_CCCC);
    rd(A_OUT, v);   check("R2 out", v, 32'h1111_2222);
    rd(A_DIR, v);   check("R2 dir", v, 32'h3333_4444);
    rd(A_BLINK, v); check("R2 blink", v, 32'h5555_6666);
    rd(A_POL, v);   check("R2 pol", v, 32'h7777_8888);
    rd(A_EMASK, v); check("R2 emask", v, 32'h9999_AAAA);
    rd(A_LMASK, v); check("R2 lmask", v, 32'hBBBB_CCCC);
  endtask

  task automatic t_output();
    do_reset();
    wr(A_DIR, 32'hFFFF_0000);
    wr(A_OUT, 32'hA5A5_A5A5);
    check("R3 pad_oe", pad_oe, 32'h0000_FFFF);
    check("R3 pad_out", pad_out, 32'h0000_A5A5);
  endtask

  task automatic t_din();
    logic [31:0] v;
    do_reset();
    pad_in = 32'h1234_5678;
    repeat (2) @(negedge clk);
    rd(A_DIN, v); check("R4 din after two edges", v, 32'h0);
    @(negedge clk);
    rd(A_DIN, v); check("R4 din after three edges", v, 32'h1234_5678);
    wr(A_POL, 32'hFFFF_0000);
    @(negedge clk);
    rd(A_DIN, v); check("R4 din with polarity", v, 32'h1234_5678 ^ 32'hFFFF_0000);
    wr(A_DIN, 32'hDEAD_BEEF);
    rd(A_DIN, v); check("R4 din write ignored", v, 32'h1234_5678 ^ 32'hFFFF_0000);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    do_reset();
    pad_in = 32'h8;
    repeat (5) @(negedge clk);
    rd(A_ECAUSE, v); check("R5 cause set", v, 32'h8);
    check("R8 unmasked edge no irq", 32'(irq_grp), 32'h0);
    pad_in = 32'h0;
    repeat (5) @(negedge clk);
    rd(A_ECAUSE, v); check("R5 cause sticky", v, 32'h8);
    wr(A_EMASK, 32'h8);
    check("R8 masked edge irq", 32'(irq_grp), 32'h1);
    wr(A_ECAUSE, ~32'h8);
    rd(A_ECAUSE, v); check("R6 ack clears", v, 32'h0);
    check("R6 irq after ack", 32'(irq_grp), 32'h0);
  endtask

  task automatic t_setwins();
    logic [31:0] v;
    do_reset();
    pad_in = 32'h400;
    repeat (5) @(negedge clk);
    pad_in = 32'h600;
    repeat (3) @(negedge clk);
    wr(A_ECAUSE, 32'hFFFF_F9FF);
    rd(A_ECAUSE, v); check("R6 set wins over clear", v, 32'h200);
  endtask

  task automatic t_level();
    do_reset();
    wr(A_LMASK, 32'h0010_0000);
    pad_in = 32'h0010_0000;
    repeat (4) @(negedge clk);
    check("R7 R9 level irq group 2", 32'(irq_grp), 32'h4);
    pad_in = 32'h0;
    repeat (4) @(negedge clk);
    check("R7 level follows input", 32'(irq_grp), 32'h0);
    wr(A_POL, 32'h0010_0000);
    @(negedge clk);
    check("R7 inverted level irq", 32'(irq_grp), 32'h4);
  endtask

  task automatic t_falling();
    logic [31:0] v;
    do_reset();
    pad_in = 32'h0200_0000;
    repeat (5) @(negedge clk);
    wr(A_POL, 32'h0200_0000);
    repeat (2) @(negedge clk);
    wr(A_ECAUSE, 32'h0);
    rd(A_ECAUSE, v); check("R11 no cause before fall", v, 32'h0);
    wr(A_EMASK, 32'h0200_0000);
    pad_in = 32'h0;
    repeat (5) @(negedge clk);
    rd(A_ECAUSE, v); check("R11 falling edge cause", v, 32'h0200_0000);
    check("R9 R11 irq group 3", 32'(irq_grp), 32'h8);
  endtask

  task automatic t_blink();
    int changes = 0;
    int in_high = 0;
    int stuck = 0;
    logic prev;
    do_reset();
    wr(A_DIR, ~32'h1);
    wr(A_BLINK, 32'h3);
    prev = pad_out[0];
    for (int i = 0; i < 4*HALF; i++) begin
      @(negedge clk);
      if (pad_out[0] != prev) changes++;
      if (pad_out[1]) in_high++;
      prev = pad_out[0];
    end
    check("R10 blink toggles", 32'(changes), 32'd4);
    check("R10 input line not blinking", 32'(in_high), 32'd0);
    wr(A_BLINK, 32'h0);
    wr(A_OUT, 32'h1);
    for (int i = 0; i < 2*HALF; i++) begin
      @(negedge clk);
      if (pad_out[0] != 1'b1) stuck++;
    end
    check("R10 static value restored", 32'(stuck), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_readback();
    t_output();
    t_din();
    t_edge();
    t_setwins();
    t_level();
    t_falling();
    t_blink();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule